// File: doc/BRIEF.md
# Extended 16-bit Execution Unit with Multiply

This unit runs the extended arithmetic and logic operations of a 16-bit processor with a register file. The decoder hands it a 5-bit operation code, two operands that are already fetched and a one-cycle start strobe. Operand B may come from a register, a memory word or an immediate; the unit cannot tell these apart. One clock edge later the unit presents the result and the sign and zero flags. It also raises a one-cycle write enable, either for the destination register or for the fixed R1:R0 pair.

Operations: inclusive OR, a flag-only AND test, five barrel shifts and rotates with a variable count, a low-word multiply (unsigned or signed) and a widening multiply (unsigned or signed). The widening multiply returns both halves of the 32-bit product. Every operation takes one slot. The carry and overflow flags belong to the surrounding core, and no operation here touches them.

The reset input is expected to be already synchronised to `clk` upstream.

Top module: `xalu16`

## Requirements
- R1: While `rst_n` is low and after it is released, `result`, `result_hi`, `flag_s`, `flag_z` and all write enables read 0 until the first accepted operation.
- R2: Op 0 (OR) yields `a|b` on `result`, pulses `wr_dest` and `flags_we`, sets `flag_s` to result bit 15 and `flag_z` to (result==0).
- R3: Op 1 (TST) sets `flag_s`/`flag_z` from `a&b` and pulses `flags_we`. It raises neither write enable, and `result` keeps its previous value.
- R4: Ops 2 (shift left), 3 (logical shift right) and 4 (arithmetic shift right) shift `a` by `b[3:0]`, ignore `b[15:4]`, write the destination and set S/Z from the 16-bit result.
- R5: Ops 5 (rotate left) and 6 (rotate right) rotate `a` by `b[3:0]`, write the destination and set S/Z from the result.
- R6: A count field of 0, including counts of 16 or 32 in `b`, returns `a` unchanged for every shift and rotate.
- R7: Ops 7 (unsigned) and 8 (signed) write the low 16 bits of `a*b` to the destination and set S/Z from that low word.
- R8: Ops 9 (unsigned) and 10 (signed) produce the 32-bit product. The high word goes on `result_hi`, the low word on `result`, and `wr_pair` pulses instead of `wr_dest`.
- R9: For ops 9 and 10, `flag_s` is product bit 31 and `flag_z` is set only when all 32 bits are zero.
- R10: Outputs update at the clock edge that samples `start` high. Write enables and `flags_we` are single-cycle pulses. With `start` low nothing changes, and `result_hi` changes only on ops 9 and 10.
- R11: Codes 11 to 31 raise no write enable and no `flags_we`, and leave `result` and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the operation on this edge |
| op | input | 5 | Operation code |
| a | input | 16 | Operand A (destination's current value) |
| b | input | 16 | Operand B or shift count |
| result | output | 16 | Result, or low word of a widening product |
| result_hi | output | 16 | High word of a widening product |
| wr_dest | output | 1 | Write `result` to the destination register |
| wr_pair | output | 1 | Write `result_hi` to R1 and `result` to R0 |
| flags_we | output | 1 | S and Z were updated this cycle |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest case is a widening product whose low word is zero while the high word is not. A low-word-only zero test would wrongly set Z here. Directed vectors such as 0x0100 times 0x0100 and 0x8000 times 0x8000 in signed form reach it. A flag-only test placed right after a write shows whether `result` holds its value. Counts of 16 and 32 exercise the truncation of the count field. Several thousand random operations follow, mixing idle cycles and undefined codes, and are checked every cycle against a behavioural model.

// File: rtl/xalu16_pkg.sv
package xalu16_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_OR    = 5'd0,
    OP_TST   = 5'd1,
    OP_SHL   = 5'd2,
    OP_SHR   = 5'd3,
    OP_SAR   = 5'd4,
    OP_ROL   = 5'd5,
    OP_ROR   = 5'd6,
    OP_MUL   = 5'd7,
    OP_IMUL  = 5'd8,
    OP_MULW  = 5'd9,
    OP_IMULW = 5'd10
  } xop_e;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROL = 3'd3,
    SK_ROR = 3'd4
  } shkind_e;

endpackage

// File: rtl/xalu16_shift.sv
module xalu16_shift
  import xalu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         val,
  input  logic [$clog2(W)-1:0] cnt,
  input  shkind_e              kind,
  output logic [W-1:0]         res
);
  localparam int CW = $clog2(W);

  // one stage of the log shifter: move by a fixed distance d
  function automatic logic [W-1:0] stage_fn(input logic [W-1:0] v,
                                            input shkind_e k,
                                            input int d);
    logic [W-1:0] o;
    case (k)
      SK_LSL:  o = v << d;
      SK_LSR:  o = v >> d;
      SK_ASR:  o = $signed(v) >>> d;
      SK_ROL:  o = (v << d) | (v >> (W - d));
      SK_ROR:  o = (v >> d) | (v << (W - d));
      default: o = v;
    endcase
    return o;
  endfunction

  logic [CW:0][W-1:0] stg;

  assign stg[0] = val;

  for (genvar i = 0; i < CW; i++) begin : g_stage
    assign stg[i+1] = cnt[i] ? stage_fn(stg[i], kind, 1 << i) : stg[i];
  end

  assign res = stg[CW];

endmodule

// File: rtl/xalu16_mul.sv
module xalu16_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           is_signed,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;

  // sign-extend to the product width; modulo-2^PW arithmetic then gives
  // the exact signed or unsigned product, which always fits in PW bits
  assign ext_a = {{W{is_signed & a[W-1]}}, a};
  assign ext_b = {{W{is_signed & b[W-1]}}, b};
  assign prod  = ext_a * ext_b;

endmodule

// File: rtl/xalu16.sv
module xalu16
  import xalu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     result,
  output logic [W-1:0]     result_hi,
  output logic             wr_dest,
  output logic             wr_pair,
  output logic             flags_we,
  output logic             flag_s,
  output logic             flag_z
);
  localparam int CW = $clog2(W);
  localparam int PW = 2 * W;

  // datapath pieces
  shkind_e        sh_kind;
  logic [W-1:0]   sh_out;
  logic           mul_signed;
  logic [PW-1:0]  prod;

  always_comb begin
    case (op)
      OP_SHR:  sh_kind = SK_LSR;
      OP_SAR:  sh_kind = SK_ASR;
      OP_ROL:  sh_kind = SK_ROL;
      OP_ROR:  sh_kind = SK_ROR;
      default: sh_kind = SK_LSL;
    endcase
  end

  assign mul_signed = (op == OP_IMUL) || (op == OP_IMULW);

  xalu16_shift #(.W(W)) u_shift (
    .val  (a),
    .cnt  (b[CW-1:0]),
    .kind (sh_kind),
    .res  (sh_out)
  );

  xalu16_mul #(.W(W)) u_mul (
    .a         (a),
    .b         (b),
    .is_signed (mul_signed),
    .prod      (prod)
  );

  // next-state decode
  logic [W-1:0] nx_res;
  logic [W-1:0] nx_hi;
  logic         ld_res;
  logic         ld_hi;
  logic         nx_wd;
  logic         nx_wp;
  logic         nx_fw;
  logic         wide;
  logic         nx_s;
  logic         nx_z;

  always_comb begin
    nx_res = '0;
    nx_hi  = prod[PW-1:W];
    ld_res = 1'b0;
    ld_hi  = 1'b0;
    nx_wd  = 1'b0;
    nx_wp  = 1'b0;
    nx_fw  = 1'b0;
    wide   = 1'b0;
    case (op)
      OP_OR: begin
        nx_res = a | b;
        ld_res = 1'b1;
        nx_wd  = 1'b1;
        nx_fw  = 1'b1;
      end
      OP_TST: begin
        nx_res = a & b;
        nx_fw  = 1'b1;
      end
      OP_SHL, OP_SHR, OP_SAR, OP_ROL, OP_ROR: begin
        nx_res = sh_out;
        ld_res = 1'b1;
        nx_wd  = 1'b1;
        nx_fw  = 1'b1;
      end
      OP_MUL, OP_IMUL: begin
        nx_res = prod[W-1:0];
        ld_res = 1'b1;
        nx_wd  = 1'b1;
        nx_fw  = 1'b1;
      end
      OP_MULW, OP_IMULW: begin
        nx_res = prod[W-1:0];
        ld_res = 1'b1;
        ld_hi  = 1'b1;
        nx_wp  = 1'b1;
        nx_fw  = 1'b1;
        wide   = 1'b1;
      end
      default: ;
    endcase
    nx_s = wide ? prod[PW-1] : nx_res[W-1];
    nx_z = wide ? (prod == '0) : (nx_res == '0);
  end

  // registers
  logic [W-1:0] res_q;
  logic [W-1:0] hi_q;
  logic         wd_q;
  logic         wp_q;
  logic         fw_q;
  logic         s_q;
  logic         z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      hi_q  <= '0;
      wd_q  <= 1'b0;
      wp_q  <= 1'b0;
      fw_q  <= 1'b0;
      s_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      wd_q <= start & nx_wd;
      wp_q <= start & nx_wp;
      fw_q <= start & nx_fw;
      if (start && ld_res) res_q <= nx_res;
      if (start && ld_hi)  hi_q  <= nx_hi;
      if (start && nx_fw) begin
        s_q <= nx_s;
        z_q <= nx_z;
      end
    end
  end

  assign result    = res_q;
  assign result_hi = hi_q;
  assign wr_dest   = wd_q;
  assign wr_pair   = wp_q;
  assign flags_we  = fw_q;
  assign flag_s    = s_q;
  assign flag_z    = z_q;

  // checks
  a_r10_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dest, wr_pair}));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!wr_dest && !wr_pair && !flags_we && $stable(result) &&
                $stable(result_hi) && $stable(flag_s) && $stable(flag_z)));

  a_r3_tst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_TST) |=> (!wr_dest && !wr_pair && flags_we && $stable(result)));

  a_r8_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_MULW || op == OP_IMULW)) |=> (wr_pair && flags_we));

  a_r9_wide_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pair |-> (flag_z == ({result_hi, result} == '0) && flag_s == result_hi[W-1]));

  a_r2_dest_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dest |-> (flag_s == result[W-1] && flag_z == (result == '0)));

  a_r11_undefined: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op > OP_IMULW) |=> (!flags_we && !wr_dest && !wr_pair &&
                                  $stable(result) && $stable(flag_s) && $stable(flag_z)));

endmodule

// File: tb/sim_xalu16.sv
module sim_xalu16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [15:0] result, result_hi;
  logic        wr_dest, wr_pair, flags_we, flag_s, flag_z;

  xalu16 #(.W(16)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .a         (a),
    .b         (b),
    .result    (result),
    .result_hi (result_hi),
    .wr_dest   (wr_dest),
    .wr_pair   (wr_pair),
    .flags_we  (flags_we),
    .flag_s    (flag_s),
    .flag_z    (flag_z)
  );

  always #4 clk = ~clk;

  // reference state
  logic [15:0] e_res = '0, e_hi = '0;
  logic        e_wd = 0, e_wp = 0, e_fw = 0, e_s = 0, e_z = 0;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;
  string       last_tag = "R1";

  task automatic check(string tag);
    n_vec++;
    if ({result, result_hi, wr_dest, wr_pair, flags_we, flag_s, flag_z} !==
        {e_res, e_hi, e_wd, e_wp, e_fw, e_s, e_z}) begin
      n_bad++;
      $display("FAIL %s: actual res=%h hi=%h wd=%b wp=%b fw=%b s=%b z=%b expected res=%h hi=%h wd=%b wp=%b fw=%b s=%b z=%b",
               tag, result, result_hi, wr_dest, wr_pair, flags_we, flag_s, flag_z,
               e_res, e_hi, e_wd, e_wp, e_fw, e_s, e_z);
    end
  endtask

  task automatic put1(logic [15:0] r, bit wr);
    if (wr) begin
      e_res = r;
      e_wd  = 1;
    end
    e_fw = 1;
    e_s  = r[15];
    e_z  = (r == 0);
  endtask

  task automatic model(bit st, logic [4:0] o, logic [15:0] x, logic [15:0] y);
    int unsigned        c;
    logic signed [15:0] sx;
    logic [31:0]        t;
    logic [63:0]        pu, ps, p;
    c  = y[3:0];
    sx = x;
    pu = longint'(x) * longint'(y);
    ps = longint'($signed(x)) * longint'($signed(y));
    e_wd = 0;
    e_wp = 0;
    e_fw = 0;
    if (st) begin
      case (o)
        5'd0: put1(x | y, 1);
        5'd1: put1(x & y, 0);
        5'd2: put1(x << c, 1);
        5'd3: put1(x >> c, 1);
        5'd4: put1(sx >>> c, 1);
        5'd5: begin t = {x, x} << c; put1(t[31:16], 1); end
        5'd6: begin t = {x, x} >> c; put1(t[15:0], 1); end
        5'd7: put1(pu[15:0], 1);
        5'd8: put1(ps[15:0], 1);
        5'd9, 5'd10: begin
          p     = (o == 5'd9) ? pu : ps;
          e_res = p[15:0];
          e_hi  = p[31:16];
          e_wp  = 1;
          e_fw  = 1;
          e_s   = p[31];
          e_z   = (p[31:0] == 0);
        end
        default: ;
      endcase
    end
  endtask

  function automatic string tag_of(bit st, logic [4:0] o);
    if (!st) return "R10";
    case (o)
      5'd0:              return "R2";
      5'd1:              return "R3";
      5'd2, 5'd3, 5'd4:  return "R4";
      5'd5, 5'd6:        return "R5";
      5'd7, 5'd8:        return "R7";
      5'd9, 5'd10:       return "R8";
      default:           return "R11";
    endcase
  endfunction

  task automatic apply(string tag, bit st, logic [4:0] o, logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    check(last_tag);
    start = st;
    op    = o;
    a     = x;
    b     = y;
    model(st, o, x, y);
    last_tag = tag;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2 OR
    apply("R2", 1, 5'd0, 16'h1200, 16'h0034);
    apply("R2", 1, 5'd0, 16'h0000, 16'h0000);
    apply("R2", 1, 5'd0, 16'h8000, 16'h0001);
    // R3 TST: flags only, result must hold
    apply("R3", 1, 5'd1, 16'h8001, 16'h8000);
    apply("R3", 1, 5'd1, 16'h00F0, 16'h0F00);
    // R4 shifts, upper count bits ignored
    apply("R4", 1, 5'd2, 16'h0001, 16'h000F);
    apply("R4", 1, 5'd3, 16'h8000, 16'h0004);
    apply("R4", 1, 5'd4, 16'h8000, 16'h0004);
    apply("R4", 1, 5'd3, 16'hF000, 16'hFF13);
    apply("R4", 1, 5'd4, 16'h4000, 16'h000E);
    // R6 zero count
    apply("R6", 1, 5'd2, 16'hABCD, 16'h0000);
    apply("R6", 1, 5'd5, 16'hABCD, 16'h0010);
    apply("R6", 1, 5'd4, 16'h9876, 16'h0020);
    apply("R6", 1, 5'd6, 16'h1357, 16'h0000);
    // R5 rotates
    apply("R5", 1, 5'd5, 16'h8001, 16'h0001);
    apply("R5", 1, 5'd6, 16'h0001, 16'h0001);
    apply("R5", 1, 5'd6, 16'h1234, 16'h0004);
    apply("R5", 1, 5'd5, 16'h1234, 16'h000F);
    // R7 low-word multiplies
    apply("R7", 1, 5'd7, 16'h0100, 16'h0100);
    apply("R7", 1, 5'd8, 16'hFFFF, 16'hFFFF);
    apply("R7", 1, 5'd8, 16'hFFFE, 16'h0003);
    apply("R7", 1, 5'd7, 16'hFFFF, 16'hFFFF);
    // R8 widening
    apply("R8", 1, 5'd9, 16'hFFFF, 16'hFFFF);
    apply("R8", 1, 5'd10, 16'hFFFF, 16'h0001);
    // R9 zero/sign over 32 bits
    apply("R9", 1, 5'd9, 16'h0100, 16'h0100);
    apply("R9", 1, 5'd10, 16'h8000, 16'h8000);
    apply("R9", 1, 5'd9, 16'h0000, 16'h1234);
    apply("R9", 1, 5'd10, 16'h8000, 16'h0001);
    // R11 undefined codes
    apply("R11", 1, 5'd11, 16'h0000, 16'h0000);
    apply("R11", 1, 5'd31, 16'hFFFF, 16'hFFFF);
    // R10 idle cycles
    apply("R10", 0, 5'd0, 16'h5555, 16'hAAAA);
    apply("R10", 0, 5'd9, 16'hFFFF, 16'hFFFF);
    apply("R10", 1, 5'd2, 16'h0003, 16'h0002);
    apply("R10", 0, 5'd1, 16'h0000, 16'h0000);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit          st;
      logic [4:0]  o;
      logic [15:0] x, y;
      st = ($urandom_range(0, 9) < 8);
      o  = ($urandom_range(0, 9) == 0) ? 5'($urandom_range(11, 31))
                                       : 5'($urandom_range(0, 10));
      x  = 16'($urandom);
      y  = 16'($urandom);
      if ($urandom_range(0, 7) == 0) x = 16'h0000;
      if ($urandom_range(0, 7) == 0) y = {12'($urandom), 4'h0};
      apply(tag_of(st, o), st, o, x, y);
    end

    apply("R10", 0, 5'd0, 16'h0000, 16'h0000);
    @(negedge clk);
    check(last_tag);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule